// File: doc/BRIEF.md
# Immediate-operand bus cycle scheduler

This block lays out the bus and idle timing of an arithmetic or logical instruction with an immediate source and a register or memory destination. A single `start` pulse gives the operand size and the destination addressing mode. The block then runs through the matching slot sequence one clock at a time. Each slot is one of four kinds: a program fetch, an operand read, an operand write, or an internal idle period.

Address arithmetic, ALU work and flag generation belong to other blocks. This block only reports which kind of slot is active on each clock and which operand half a long transfer is handling. It also keeps a running count of the clocks spent on the instruction. When the last slot ends it raises a one-clock `done`, and `cycle_count` then holds the instruction's total length in clocks.

A bus slot lasts `BUS_CLKS` clocks, which is 4 by default. The short idle slot used for address preparation lasts `HALF_CLKS` clocks, which is 2 by default. The long idle slot lasts `BUS_CLKS` clocks.

Top module: `imm_bus_sched`

## Requirements
- R1: After reset, `busy` and `done` are 0, `slot_kind` is 0 (none), `upper_word` is 0 and `cycle_count` is 0.
- R2: `slot_kind` codes are as follows: 0 means no slot, 1 a program fetch, 2 an operand read, 3 an operand write, and 4 an internal idle period. Each code is held for every clock of its slot.
- R3: With `ea_mode` 0 (data register) and `is_long` 0, the sequence is fetch, fetch. With default parameters that totals 8 clocks.
- R4: With `ea_mode` 0 and `is_long` 1, the sequence is fetch, fetch, fetch, then a `BUS_CLKS`-clock idle slot. With default parameters that totals 16 clocks.
- R5: A memory destination with `is_long` 0 runs in this order: the immediate fetch, any address extension fetches, one read, one fetch, then one write. For `ea_mode` 1 (indirect) and 2 (postincrement) this totals 16 clocks.
- R6: `ea_mode` 3 (predecrement) and 5 (indexed) place a `HALF_CLKS`-clock idle slot directly after the immediate fetches. This makes predecrement 2 clocks longer than indirect, and indexed 2 clocks longer than displacement.
- R7: `ea_mode` 4 (16-bit displacement), 5 (indexed) and 6 (absolute word) add one extension fetch. `ea_mode` 7 (absolute long) adds two.
- R8: A long memory operation fetches the immediate twice. Its data order is read upper, read lower, fetch, write lower, write upper. `upper_word` is 1 exactly during the slots that handle the upper half. A long operation to absolute long memory totals 36 clocks.
- R9: `done` pulses for one clock in the clock after the last slot. At that point `cycle_count` equals the total number of clocks in the sequence, and it holds that value until the next accepted start.
- R10: A `start` that arrives while `busy` is 1 is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only while idle) |
| is_long | input | 1 | 1 = long operand, 0 = byte or word |
| ea_mode | input | 3 | Destination addressing mode code |
| busy | output | 1 | A sequence is running |
| slot_kind | output | 3 | Kind of the current slot |
| upper_word | output | 1 | Current read/write handles the upper half |
| done | output | 1 | One-clock pulse after the final slot |
| cycle_count | output | CW | Clocks spent in the current or last sequence |

## Verification
The bench builds the block with its default parameters. With 4-clock bus slots and 2-clock half-idle slots, every total can be compared against the fixed figures in the requirements: 8, 16 and 36 clocks. The bench runs all eight addressing modes at both sizes and compares each clock's slot code and half flag. That brings every extension-fetch count and both idle insertions within reach. One start pulse is sent in the middle of a long run to exercise the ignore rule.

// File: rtl/imm_bus_sched.sv
module imm_bus_sched #(
  parameter int BUS_CLKS  = 4,
  parameter int HALF_CLKS = 2,
  parameter int CW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_long,
  input  logic [2:0]    ea_mode,
  output logic          busy,
  output logic [2:0]    slot_kind,
  output logic          upper_word,
  output logic          done,
  output logic [CW-1:0] cycle_count
);
  localparam int MAXS = 10;
  localparam int SEQW = (MAXS + 1) * 4;
  localparam int SW   = $clog2(BUS_CLKS + 1);
  localparam logic [SW-1:0] BUS_LAST  = SW'(BUS_CLKS - 1);
  localparam logic [SW-1:0] HALF_LAST = SW'(HALF_CLKS - 1);

  localparam logic [3:0] C_PROG  = 4'd1;
  localparam logic [3:0] C_RD    = 4'd2;
  localparam logic [3:0] C_WR    = 4'd3;
  localparam logic [3:0] C_IDLE2 = 4'd4;
  localparam logic [3:0] C_IDLE4 = 4'd5;
  localparam logic [3:0] HI      = 4'd8;

  function automatic logic [SEQW-1:0] build(input logic lg, input logic [2:0] m);
    logic [SEQW-1:0] s;
    int n;
    s = '0;
    n = 0;
    s[n*4 +: 4] = C_PROG; n = n + 1;
    if (lg) begin s[n*4 +: 4] = C_PROG; n = n + 1; end
    if (m == 3'd0) begin
      s[n*4 +: 4] = C_PROG; n = n + 1;
      if (lg) begin s[n*4 +: 4] = C_IDLE4; n = n + 1; end
    end else begin
      if (m == 3'd3 || m == 3'd5) begin s[n*4 +: 4] = C_IDLE2; n = n + 1; end
      if (m == 3'd4 || m == 3'd5 || m == 3'd6 || m == 3'd7) begin
        s[n*4 +: 4] = C_PROG; n = n + 1;
      end
      if (m == 3'd7) begin s[n*4 +: 4] = C_PROG; n = n + 1; end
      if (lg) begin
        s[n*4 +: 4] = C_RD | HI; n = n + 1;
      end
      s[n*4 +: 4] = C_RD;   n = n + 1;
      s[n*4 +: 4] = C_PROG; n = n + 1;
      s[n*4 +: 4] = C_WR;   n = n + 1;
      if (lg) begin s[n*4 +: 4] = C_WR | HI; n = n + 1; end
    end
    return s;
  endfunction

  logic [SEQW-1:0] seq_q;
  logic [3:0]      idx;
  logic [SW-1:0]   sub;
  logic [5:0]      base;
  logic [3:0]      cur, nxt;
  logic            slot_end;

  assign base     = {idx, 2'b00};
  assign cur      = seq_q[base +: 4];
  assign nxt      = seq_q[base + 6'd4 +: 4];
  assign slot_end = sub == ((cur[2:0] == C_IDLE2[2:0]) ? HALF_LAST : BUS_LAST);

  assign slot_kind  = !busy ? 3'd0 : (cur[2:0] == C_IDLE4[2:0]) ? 3'd4 : cur[2:0];
  assign upper_word = busy & cur[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q       <= '0;
      idx         <= '0;
      sub         <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      cycle_count <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          seq_q       <= build(is_long, ea_mode);
          idx         <= '0;
          sub         <= '0;
          busy        <= 1'b1;
          cycle_count <= '0;
        end
      end else begin
        cycle_count <= cycle_count + 1'b1;
        if (slot_end) begin
          sub <= '0;
          if (nxt[2:0] == 3'd0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/imm_bus_sched_chk.sv
module imm_bus_sched_chk #(parameter int CW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [2:0]    slot_kind,
  input logic          upper_word,
  input logic          done,
  input logic [CW-1:0] cycle_count
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (slot_kind == 3'd0 && !upper_word));
  p_busy_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot_kind != 3'd0 && slot_kind <= 3'd4));
  p_upper_rw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upper_word |-> (slot_kind == 3'd2 || slot_kind == 3'd3));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cycle_count == $past(cycle_count) + 1'b1);
  p_start_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind imm_bus_sched imm_bus_sched_chk #(.CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .slot_kind(slot_kind), .upper_word(upper_word), .done(done),
  .cycle_count(cycle_count)
);

// File: tb/test_imm_bus_sched.sv
module test_imm_bus_sched;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_long = 1'b0;
  logic [2:0] ea_mode = 3'd0;
  logic busy, upper_word, done;
  logic [2:0] slot_kind;
  logic [CW-1:0] cycle_count;

  int checks = 0, errors = 0;
  int exp_q[$];
  string req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_bus_sched #(.CW(CW)) i_imm_bus_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .is_long(is_long), .ea_mode(ea_mode),
    .busy(busy), .slot_kind(slot_kind), .upper_word(upper_word), .done(done),
    .cycle_count(cycle_count));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected item: kind*2 + upper, one per clock; 1000 + total marks done.
  task automatic put(input int kind, input int hi, input int clocks, input string req, inout int total);
    for (int i = 0; i < clocks; i++) begin
      exp_q.push_back(kind * 2 + hi);
      req_q.push_back(req);
    end
    total += clocks;
  endtask

  task automatic plan_run(input bit lg, input int m, output int total);
    string r;
    total = 0;
    r = (m == 0) ? (lg ? "R4" : "R3") : (lg ? "R8" : "R5");
    put(1, 0, 4, "R2", total);
    if (lg) put(1, 0, 4, r, total);
    if (m == 0) begin
      put(1, 0, 4, r, total);
      if (lg) put(4, 0, 4, "R4", total);
    end else begin
      if (m == 3 || m == 5) put(4, 0, 2, "R6", total);
      if (m >= 4) put(1, 0, 4, "R7", total);
      if (m == 7) put(1, 0, 4, "R7", total);
      if (lg) put(2, 1, 4, "R8", total);
      put(2, 0, 4, r, total);
      put(1, 0, 4, r, total);
      put(3, 0, 4, r, total);
      if (lg) put(3, 1, 4, "R8", total);
    end
    exp_q.push_back(1000 + total);
    req_q.push_back("R9");
  endtask

  task automatic run(input bit lg, input int m, input int lit_total, input bit poke);
    int total;
    plan_run(lg, m, total);
    if (lit_total > 0) check(total == lit_total, "R5 total", total, lit_total);
    @(posedge clk); #1;
    is_long = lg; ea_mode = 3'(m); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (5) @(posedge clk);
      #1; is_long = 1'b0; ea_mode = 3'd0; start = 1'b1;  // R10 ignored
      @(posedge clk); #1; start = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(posedge clk); #1;
    check(cycle_count == CW'(total), "R9 hold", int'(cycle_count), total);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (slot_kind != 3'd0 || done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 stray", int'(slot_kind), 0);
        end else begin
          int e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (e >= 1000) begin
            check(done && slot_kind == 3'd0, r, int'(done), 1);
            check(int'(cycle_count) == e - 1000, r, int'(cycle_count), e - 1000);
          end else begin
            check(!done && int'(slot_kind) * 2 + int'(upper_word) == e, r,
                  int'(slot_kind) * 2 + int'(upper_word), e);
          end
        end
      end else if (exp_q.size() != 0 && busy) begin
        check(1'b0, "R2 empty slot", int'(slot_kind), exp_q[0] / 2);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && slot_kind == 0 && !upper_word && cycle_count == 0,
          "R1", int'(busy) + int'(done) + int'(slot_kind) + int'(cycle_count), 0);
    run(1'b0, 0, 8, 1'b0);    // R3
    run(1'b1, 0, 16, 1'b0);   // R4
    run(1'b0, 1, 16, 1'b0);   // R5
    run(1'b0, 2, 16, 1'b0);   // R5
    run(1'b0, 3, 18, 1'b0);   // R6
    run(1'b0, 4, 20, 1'b0);   // R7
    run(1'b0, 5, 22, 1'b0);   // R6 R7
    run(1'b0, 6, 20, 1'b0);   // R7
    run(1'b0, 7, 24, 1'b0);   // R7
    for (int m = 1; m < 7; m++) run(1'b1, m, 0, 1'b0);  // R8
    run(1'b1, 7, 36, 1'b1);   // R8 R10
    repeat (4) @(negedge clk);
    check(!busy && slot_kind == 0, "R10 idle", int'(slot_kind), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule